// File: doc/BRIEF.md
# Windowed Watchdog Reset Supervisor

This block is a synchronous supervisor that keeps a processor in a defined state. It combines three functions. The first is a power-up delay that holds reset after the supply becomes good. The second is a brown-out override that drops reset as soon as the filtered supply-good flag goes away. The third is a windowed watchdog. The watchdog demands a service inside a bounded interval and resets the processor when a service comes too early or too late.

The block also drives an active-low system enable. Enable is held off after every reset until the software has serviced the watchdog inside the window three times in a row. Actuators that hang off this enable therefore stay de-energised while a faulty program keeps restarting.

Every duration comes from one base period, `TWD_TICKS`, counted in clock cycles:

| Duration | Length |
|---|---|
| Closed window | 4·TWD/5 |
| Open window | 2·TWD/5 |
| Reset pulse | TWD/40 |
| Power-up delay | TWD |

Each duration is rounded down and never shorter than one cycle.

Top module: `wd_supervisor`

## Requirements
- R1: While `rst_ni` is low, `rst_n_o` is 0 and `en_n_o` is 1.
- R2: Once the filtered supply flag becomes good, `rst_n_o` stays 0 for exactly TWD cycles and then goes to 1. A falling edge on `clr_i` during this delay has no effect.
- R3: A service is a 1-to-0 transition of `clr_i`. It passes through a two-flop synchronizer, so it acts on the third rising clock edge after `clr_i` is first sampled low. A service acting in the open window keeps `rst_n_o` at 1 and restarts the closed window. This holds on the first and on the last cycle of the open window, which are cycles C+1 and C+O after the window start.
- R4: `en_n_o` goes to 0 on the third consecutive in-window service after a reset. It stays 0 through further in-window services.
- R5: A service acting in the closed window drives `rst_n_o` to 0 for P cycles. The last such cycle is cycle C after the window start. A new closed window then starts when `rst_n_o` returns to 1.
- R6: If no service arrives, `rst_n_o` falls C+O cycles after the window start and stays 0 for P cycles. Without service this repeats with a period of C+O+P.
- R7: `en_n_o` is 1 whenever `rst_n_o` is 0. An early or a late fault restarts the count of consecutive in-window services from zero.
- R8: A falling edge of `clr_i` that acts while the reset pulse is driven is ignored. It changes neither the pulse length nor the timing of the next window.
- R9: When `supply_ok_i` is low for FILTER_TICKS consecutive samples, `rst_n_o` goes to 0 and `en_n_o` to 1 one cycle after the last of those samples. A low run shorter than that leaves both outputs unchanged.
- R10: After a brown-out, `clr_i` edges have no effect. Reset is released only after a full new power-up delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Time base clock |
| rst_ni | input | 1 | Asynchronous block reset, active low |
| supply_ok_i | input | 1 | Synchronous supply-good comparator flag |
| clr_i | input | 1 | Watchdog clear input; a falling edge is a service |
| rst_n_o | output | 1 | Processor reset, active low, registered |
| en_n_o | output | 1 | System enable, active low, registered |

## Verification
All results are timed on a free-running count of clock edges in the bench. Suppose `clr_i` is driven low just after edge M. The service then acts at edge M+3, and the window origin moves to that edge.

Suppose `supply_ok_i` is driven low just after edge m. Reset is then due at edge m+FILTER_TICKS+1. If the supply is driven good just after edge s, reset rises at edge s+1+TWD.

Each check samples on the falling clock edge that follows the edge on which a change is due. For each boundary, a second check is made one edge earlier, which pins both sides of every transition.

// File: rtl/wdsup_pkg.sv
package wdsup_pkg;

  typedef enum logic [1:0] {
    WD_POR,
    WD_CLOSED,
    WD_OPEN,
    WD_PULSE
  } wd_state_e;

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

endpackage

// File: rtl/wdsup_supply_filter.sv
module wdsup_supply_filter #(
  parameter int FILTER_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic good_o
);
  localparam int FT = wdsup_pkg::at_least_one(FILTER_TICKS);
  localparam int CW = $clog2(FT + 1);

  logic [CW-1:0] low_cnt;

  // good rises at once, falls only after FT low samples in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= '0;
      good_o  <= 1'b0;
    end else if (raw_i) begin
      low_cnt <= '0;
      good_o  <= 1'b1;
    end else if (low_cnt >= CW'(FT - 1)) begin
      good_o  <= 1'b0;
    end else begin
      low_cnt <= low_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdsup_clr_edge.sv
module wdsup_clr_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  output logic fall_o
);
  localparam int NS = (SYNC_STAGES < 1) ? 1 : SYNC_STAGES;

  // [NS-1:0] synchronizer, [NS] previous synchronized value
  logic [NS:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) shift_q <= '1;
    else         shift_q <= {shift_q[NS-1:0], clr_i};
  end

  assign fall_o = shift_q[NS] & ~shift_q[NS-1];
endmodule

// File: rtl/wdsup_window_fsm.sv
module wdsup_window_fsm
  import wdsup_pkg::*;
#(
  parameter int TWD_TICKS     = 1000,
  parameter int GOOD_SERVICES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic good_i,
  input  logic fall_i,
  output logic rst_n_o,
  output logic en_n_o
);
  localparam int POR_T    = at_least_one(TWD_TICKS);
  localparam int CLOSED_T = at_least_one((4 * TWD_TICKS) / 5);
  localparam int OPEN_T   = at_least_one((2 * TWD_TICKS) / 5);
  localparam int PULSE_T  = at_least_one(TWD_TICKS / 40);
  localparam int NEED     = at_least_one(GOOD_SERVICES);
  localparam int TW       = $clog2(POR_T + 1);
  localparam int SW       = $clog2(NEED + 1);

  wd_state_e     state_q;
  logic [TW-1:0] tmr_q;
  logic [SW-1:0] svc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WD_POR;
      tmr_q   <= '0;
      svc_q   <= '0;
      rst_n_o <= 1'b0;
      en_n_o  <= 1'b1;
    end else if (!good_i) begin
      // brown-out override: restart the whole power-up sequence
      state_q <= WD_POR;
      tmr_q   <= '0;
      svc_q   <= '0;
      rst_n_o <= 1'b0;
      en_n_o  <= 1'b1;
    end else begin
      unique case (state_q)
        WD_POR: begin
          if (tmr_q == TW'(POR_T - 1)) begin
            state_q <= WD_CLOSED;
            tmr_q   <= '0;
            rst_n_o <= 1'b1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        WD_CLOSED: begin
          if (fall_i) begin
            state_q <= WD_PULSE;
            tmr_q   <= '0;
            svc_q   <= '0;
            rst_n_o <= 1'b0;
            en_n_o  <= 1'b1;
          end else if (tmr_q == TW'(CLOSED_T - 1)) begin
            state_q <= WD_OPEN;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        WD_OPEN: begin
          if (fall_i) begin
            state_q <= WD_CLOSED;
            tmr_q   <= '0;
            if (svc_q < SW'(NEED))      svc_q  <= svc_q + 1'b1;
            if (svc_q >= SW'(NEED - 1)) en_n_o <= 1'b0;
          end else if (tmr_q == TW'(OPEN_T - 1)) begin
            state_q <= WD_PULSE;
            tmr_q   <= '0;
            svc_q   <= '0;
            rst_n_o <= 1'b0;
            en_n_o  <= 1'b1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        WD_PULSE: begin
          // clear edges ignored here
          if (tmr_q == TW'(PULSE_T - 1)) begin
            state_q <= WD_CLOSED;
            tmr_q   <= '0;
            rst_n_o <= 1'b1;
          end else begin
            tmr_q <= tmr_q + 1'b1;
          end
        end
        default: begin
          state_q <= WD_POR;
          tmr_q   <= '0;
        end
      endcase
    end
  end
endmodule

// File: rtl/wd_supervisor.sv
module wd_supervisor #(
  parameter int TWD_TICKS     = 1000,
  parameter int FILTER_TICKS  = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int GOOD_SERVICES = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic clr_i,
  output logic rst_n_o,
  output logic en_n_o
);
  logic supply_good;
  logic clr_fall;

  wdsup_supply_filter #(
    .FILTER_TICKS(FILTER_TICKS)
  ) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .raw_i (supply_ok_i),
    .good_o(supply_good)
  );

  wdsup_clr_edge #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .fall_o(clr_fall)
  );

  wdsup_window_fsm #(
    .TWD_TICKS    (TWD_TICKS),
    .GOOD_SERVICES(GOOD_SERVICES)
  ) u_fsm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .good_i (supply_good),
    .fall_i (clr_fall),
    .rst_n_o(rst_n_o),
    .en_n_o (en_n_o)
  );
endmodule

// File: rtl/wd_supervisor_chk.sv
module wd_supervisor_chk #(
  parameter int TWD_TICKS    = 1000,
  parameter int FILTER_TICKS = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic supply_ok_i,
  input logic rst_n_o,
  input logic en_n_o
);
  localparam int PULSE_T = wdsup_pkg::at_least_one(TWD_TICKS / 40);
  localparam int FT      = wdsup_pkg::at_least_one(FILTER_TICKS);

  int unsigned low_run;
  int unsigned rst_low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_run     <= 0;
      rst_low_run <= 0;
    end else begin
      if (supply_ok_i)         low_run <= 0;
      else if (low_run < FT)   low_run <= low_run + 1;
      if (rst_n_o)             rst_low_run <= 0;
      else if (rst_low_run < PULSE_T) rst_low_run <= rst_low_run + 1;
    end
  end

  // R7
  en_off_in_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_n_o |-> en_n_o);

  // R4
  en_on_needs_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(en_n_o) |-> rst_n_o);

  // R7
  en_off_with_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_n_o) |-> !rst_n_o);

  // R9
  brownout_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (low_run >= FT) |=> !rst_n_o);

  // R5
  pulse_min_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_n_o) |-> (rst_low_run >= PULSE_T - 1));
endmodule

bind wd_supervisor wd_supervisor_chk #(
  .TWD_TICKS   (TWD_TICKS),
  .FILTER_TICKS(FILTER_TICKS)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .supply_ok_i(supply_ok_i),
  .rst_n_o    (rst_n_o),
  .en_n_o     (en_n_o)
);

// File: tb/sim_wd_supervisor.sv
`timescale 1ns/1ps
module sim_wd_supervisor;
  localparam int TWD = 200;
  localparam int FT  = 3;
  localparam int C   = 160;
  localparam int O   = 80;
  localparam int P   = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b0;
  logic clr = 1'b1;
  logic rst_n, en_n;
  int   cyc = 0;
  int   n_chk = 0;
  int   n_fail = 0;
  int   org;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wd_supervisor #(.TWD_TICKS(TWD), .FILTER_TICKS(FT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .clr_i(clr),
    .rst_n_o(rst_n), .en_n_o(en_n)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at edge %0d: actual %b expected %b", req, what, cyc, act, exp);
    end
  endtask

  task automatic wait_until(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  // service that acts on edge e; returns at the negedge after e
  task automatic service(input int e);
    wait_until(e - 3);
    clr = 1'b0;
    wait_until(e);
    clr = 1'b1;
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    chk("R1", "rst_n_o in reset", rst_n, 1'b0);
    chk("R1", "en_n_o in reset", en_n, 1'b1);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_power_up();
    int s;
    s = cyc;
    supply_ok = 1'b1;
    service(s + 60);             // ignored during the delay (R2)
    wait_until(s + TWD);
    chk("R2", "rst still low end of delay", rst_n, 1'b0);
    wait_until(s + TWD + 1);
    chk("R2", "rst released after TWD", rst_n, 1'b1);
    chk("R2", "en off after release", en_n, 1'b1);
    org = s + TWD + 1;
  endtask

  task automatic t_three_services();
    service(org + 200); org += 200;
    chk("R3", "mid-window service no reset", rst_n, 1'b1);
    chk("R4", "en off after 1 service", en_n, 1'b1);
    service(org + 200); org += 200;
    chk("R4", "en off after 2 services", en_n, 1'b1);
    service(org + 200); org += 200;
    chk("R4", "en on after 3 services", en_n, 1'b0);
  endtask

  task automatic t_open_bounds();
    service(org + C + 1); org += C + 1;
    chk("R3", "first open tick accepted", rst_n, 1'b1);
    service(org + C + O); org += C + O;
    chk("R3", "last open tick accepted", rst_n, 1'b1);
    chk("R4", "en stays on", en_n, 1'b0);
  endtask

  task automatic t_early();
    service(org + C);
    chk("R5", "early service resets", rst_n, 1'b0);
    chk("R7", "en off on early fault", en_n, 1'b1);
    wait_until(org + C + P - 1);
    chk("R5", "pulse still low", rst_n, 1'b0);
    wait_until(org + C + P);
    chk("R5", "pulse ends after P", rst_n, 1'b1);
    org += C + P;
    service(org + 200); org += 200;
    service(org + 200); org += 200;
    chk("R7", "count restarted, en off after 2", en_n, 1'b1);
    service(org + 200); org += 200;
    chk("R4", "en on after 3 new services", en_n, 1'b0);
  endtask

  task automatic t_late_and_pulse_edge();
    int a;
    a = org + C + O;
    wait_until(a - 1);
    chk("R6", "no reset before window end", rst_n, 1'b1);
    clr = 1'b0;                  // acts at a+2, inside the pulse
    wait_until(a);
    chk("R6", "late reset asserted", rst_n, 1'b0);
    chk("R7", "en off on late fault", en_n, 1'b1);
    wait_until(a + 3);
    clr = 1'b1;
    wait_until(a + P - 1);
    chk("R8", "pulse length unchanged", rst_n, 1'b0);
    wait_until(a + P);
    chk("R8", "pulse ends on time", rst_n, 1'b1);
    wait_until(a + P + C + O - 1);
    chk("R8", "edge in pulse did not restart", rst_n, 1'b1);
    wait_until(a + P + C + O);
    chk("R6", "repeating reset period", rst_n, 1'b0);
    org = a + 2 * P + C + O;
    wait_until(org);
    chk("R6", "second pulse ends", rst_n, 1'b1);
    chk("R7", "en still off", en_n, 1'b1);
  endtask

  task automatic t_brownout();
    int m;
    service(org + 200); org += 200;
    service(org + 200); org += 200;
    service(org + 200); org += 200;
    chk("R4", "en on before brown-out", en_n, 1'b0);
    m = org + 20;
    wait_until(m);
    supply_ok = 1'b0;
    wait_until(m + FT - 1);
    supply_ok = 1'b1;
    wait_until(m + FT + 3);
    chk("R9", "short glitch ignored rst", rst_n, 1'b1);
    chk("R9", "short glitch ignored en", en_n, 1'b0);
    m = org + 40;
    wait_until(m);
    supply_ok = 1'b0;
    wait_until(m + FT);
    chk("R9", "rst high before filter", rst_n, 1'b1);
    wait_until(m + FT + 1);
    chk("R9", "brown-out forces reset", rst_n, 1'b0);
    chk("R9", "brown-out disables en", en_n, 1'b1);
    service(m + FT + 10);
    chk("R10", "clear ignored while down", rst_n, 1'b0);
    wait_until(m + 30);
    supply_ok = 1'b1;
    service(m + 30 + 50);
    wait_until(m + 30 + TWD);
    chk("R10", "full delay after brown-out", rst_n, 1'b0);
    wait_until(m + 30 + TWD + 1);
    chk("R10", "released after new delay", rst_n, 1'b1);
    chk("R10", "en off after re-power", en_n, 1'b1);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_three_services();
    t_open_bounds();
    t_early();
    t_late_and_pulse_edge();
    t_brownout();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (30000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung at edge %0d", cyc);
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule